// File: doc/BRIEF.md
# Funnel Shift Left Unit

This execution unit joins two 32-bit operands into one 64-bit value, with one as the upper word and the other as the lower word. It shifts that value left and returns the upper 32 bits. All of its controls come from a 64-bit instruction word: a range type, an extension mode, a wrap flag, a 6-bit immediate amount and a condition-code request. A select input chooses whether the shift amount is that immediate or a 32-bit register operand.

The range type sets the width that governs the amount, either 32 or 64. The wrap flag decides what happens to an amount outside that range. With wrap set, the amount is reduced modulo the width. With wrap clear, it is saturated to the span from zero to the width. The block supports only the plain extension mode and does not produce condition codes. When either of these is requested, it raises a flag beside the result. The result, the flag and a valid strobe are all registered, so they appear one clock after the request.

Top module: `funnel_shl_unit`

## Requirements
- R1: The instruction fields are fixed as follows. The range type is in bits [38:37], the extension mode in bits [49:48], the wrap flag in bit 50, the condition-code request in bit 47 and the immediate amount in bits [25:20]. When `use_imm` is 1 the immediate is the amount; otherwise `amt_reg` is the amount.
- R2: A range type of 0 gives a width of 32. Range types 1, 2 and 3 all give a width of 64.
- R3: With wrap set (bit 50 = 1), the effective amount is the raw amount ANDed with width-1. For a register amount this uses the low bits of `amt_reg`.
- R4: With wrap clear, the effective amount is saturated. A register amount is read as signed, so any negative value becomes 0. Any amount above the width, from the register or the immediate, becomes the width.
- R5: At width 32 with effective amount s, the result is (hi << s) | (lo >> (32-s)), where a term shifted by exactly 32 is 0. So s=0 returns `hi_word` and s=32 returns `lo_word`.
- R6: At width 64, s=0 returns `hi_word`. For s from 1 to 31 the result is (hi << s) | (lo >> (32-s)). For s from 32 to 63 it is lo << (s-32). For s=64 it is 0.
- R7: `out_unsupported` is 1 with the result when the extension mode is not 0 or the condition-code request bit is 1. Otherwise it is 0. In both cases the result is computed as for mode 0.
- R8: A request taken with `in_valid`=1 at a clock edge produces `out_valid`=1, together with its result, immediately after that edge.
- R9: After an edge where `in_valid` is 0, `out_valid` is 0 and `out_result` and `out_unsupported` keep their values.
- R10: While `rst_n` is low, `out_valid`, `out_result` and `out_unsupported` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| instr | input | 64 | Instruction word holding the shift controls |
| use_imm | input | 1 | 1 selects the immediate amount, 0 selects `amt_reg` |
| amt_reg | input | 32 | Register shift amount, signed |
| hi_word | input | 32 | Upper word of the operand pair |
| lo_word | input | 32 | Lower word of the operand pair |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Upper word of the shifted pair |
| out_unsupported | output | 1 | Unsupported mode or condition-code request |

## Verification
Each request reaches the ports one cycle after it is issued, so any fault in the amount normaliser or the shifter stages shows in `out_result` on the very next edge. A wrong width choice or a wrong saturation bound shows first at the amounts 32, 64 and negative values. A wrong funnel stage corrupts only the amounts whose matching bit is set. A stale output register shows during idle cycles, because `out_result` then changes or `out_valid` stays high.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

   localparam int INSTR_W   = 64;
   localparam int IMM_LSB   = 20;
   localparam int IMM_W     = 6;
   localparam int TYPE_LSB  = 37;
   localparam int CC_BIT    = 47;
   localparam int XMODE_LSB = 48;
   localparam int WRAP_BIT  = 50;

   typedef enum logic [1:0] {
      RANGE_NARROW = 2'd0,
      RANGE_RSVD   = 2'd1,
      RANGE_WIDE_U = 2'd2,
      RANGE_WIDE_S = 2'd3
   } range_e;

   typedef struct packed {
      range_e             rtype;
      logic [1:0]         xmode;
      logic               wrap;
      logic               cc_req;
      logic [IMM_W-1:0]   imm;
   } shf_ctl_t;

endpackage

// File: rtl/fsl_decode.sv
module fsl_decode
   import fsl_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output shf_ctl_t           ctl,
   output logic               wide,
   output logic               unsupported
);

   logic unused_instr_bits;

   always_comb begin
      ctl.rtype  = range_e'(instr[TYPE_LSB +: 2]);
      ctl.xmode  = instr[XMODE_LSB +: 2];
      ctl.wrap   = instr[WRAP_BIT];
      ctl.cc_req = instr[CC_BIT];
      ctl.imm    = instr[IMM_LSB +: IMM_W];
   end

   // every type other than the narrow one selects the double-width range
   assign wide        = (ctl.rtype != RANGE_NARROW);
   assign unsupported = (ctl.xmode != 2'd0) | ctl.cc_req;

   assign unused_instr_bits = ^instr;

endmodule

// File: rtl/fsl_amount.sv
module fsl_amount
   import fsl_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(2*DATA_W) + 1
)(
   input  logic              use_imm,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic              wide,
   input  logic              wrap,
   output logic [AMT_W-1:0]  amt
);

   logic [AMT_W-1:0]  span;
   logic [DATA_W-1:0] raw;
   logic              negative;
   logic [AMT_W-1:0]  wrapped;
   logic [AMT_W-1:0]  clamped;

   assign span     = wide ? AMT_W'(2*DATA_W) : AMT_W'(DATA_W);
   assign raw      = use_imm ? DATA_W'(imm) : amt_reg;
   assign negative = ~use_imm & amt_reg[DATA_W-1];

   // modulo the span: span is a power of two so span-1 is a low-bit mask
   assign wrapped  = raw[AMT_W-1:0] & (span - AMT_W'(1));

   always_comb begin
      if (negative)
         clamped = '0;
      else if (raw > DATA_W'(span))
         clamped = span;
      else
         clamped = raw[AMT_W-1:0];
   end

   assign amt = wrap ? wrapped : clamped;

endmodule

// File: rtl/fsl_funnel.sv
module fsl_funnel #(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(2*DATA_W) + 1,
   localparam int PAIR_W = 2*DATA_W
)(
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] res
);

   logic [PAIR_W-1:0] stage [0:AMT_W];

   assign stage[0] = {hi, lo};

   // logarithmic shifter: stage g shifts by 2**g; the top stage clears the pair
   for (genvar g = 0; g < AMT_W; g++) begin : g_stage
      localparam int STEP = 2**g;
      if (STEP >= PAIR_W) begin : g_clear
         assign stage[g+1] = amt[g] ? '0 : stage[g];
      end else begin : g_shift
         assign stage[g+1] = amt[g] ? {stage[g][PAIR_W-STEP-1:0], {STEP{1'b0}}}
                                    : stage[g];
      end
   end

   assign res = stage[AMT_W][PAIR_W-1 -: DATA_W];

endmodule

// File: rtl/funnel_shl_unit.sv
module funnel_shl_unit
   import fsl_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [63:0]        instr,
   input  logic               use_imm,
   input  logic [DATA_W-1:0]  amt_reg,
   input  logic [DATA_W-1:0]  hi_word,
   input  logic [DATA_W-1:0]  lo_word,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_result,
   output logic               out_unsupported
);

   localparam int AMT_W = $clog2(2*DATA_W) + 1;

   initial begin
      assert ((DATA_W >= 8) && ((DATA_W & (DATA_W - 1)) == 0))
         else $error("DATA_W must be a power of two of at least 8");
      assert ($clog2(2*DATA_W) >= IMM_W)
         else $error("immediate field wider than the amount range");
      assert (INSTR_W == 64)
         else $error("instruction word must be 64 bits");
   end

   shf_ctl_t          ctl;
   logic              wide;
   logic              unsup;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] res;

   fsl_decode u_decode (
      .instr       (instr),
      .ctl         (ctl),
      .wide        (wide),
      .unsupported (unsup)
   );

   fsl_amount #(.DATA_W(DATA_W)) u_amount (
      .use_imm (use_imm),
      .imm     (ctl.imm),
      .amt_reg (amt_reg),
      .wide    (wide),
      .wrap    (ctl.wrap),
      .amt     (amt)
   );

   fsl_funnel #(.DATA_W(DATA_W)) u_funnel (
      .hi  (hi_word),
      .lo  (lo_word),
      .amt (amt),
      .res (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_result      <= '0;
         out_unsupported <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result      <= res;
            out_unsupported <= unsup;
         end
      end
   end

endmodule

// File: rtl/funnel_shl_checker.sv
module funnel_shl_checker #(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [63:0]       instr,
   input logic              use_imm,
   input logic [DATA_W-1:0] amt_reg,
   input logic [DATA_W-1:0] hi_word,
   input logic [DATA_W-1:0] lo_word,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic              out_unsupported
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_valid_step_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_valid == $past(in_valid));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(in_valid) |-> ($stable(out_result) && $stable(out_unsupported) && !out_valid));

   p_zero_amount_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_imm && instr[25:20] == 6'd0) |=> (out_result == $past(hi_word)));

   p_narrow_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_imm && instr[38:37] == 2'd0 && !instr[50] && instr[25:20] >= 6'd32)
      |=> (out_result == $past(lo_word)));

   p_wide_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !use_imm && instr[38:37] != 2'd0 && !instr[50] &&
       $signed(amt_reg) >= $signed(2*DATA_W)) |=> (out_result == '0));

   p_flag_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (instr[49:48] != 2'd0 || instr[47])) |=> out_unsupported);

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[49:48] == 2'd0 && !instr[47]) |=> !out_unsupported);

endmodule

bind funnel_shl_unit funnel_shl_checker #(.DATA_W(DATA_W)) u_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .instr           (instr),
   .use_imm         (use_imm),
   .amt_reg         (amt_reg),
   .hi_word         (hi_word),
   .lo_word         (lo_word),
   .out_valid       (out_valid),
   .out_result      (out_result),
   .out_unsupported (out_unsupported)
);

// File: tb/funnel_shl_unit_bench.sv
module funnel_shl_unit_bench;

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic [63:0] instr;
   logic        use_imm;
   logic [31:0] amt_reg;
   logic [31:0] hi_word;
   logic [31:0] lo_word;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_unsupported;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   funnel_shl_unit u_funnel_shl_unit (
      .clk             (clk),
      .rst_n           (rst_n),
      .in_valid        (in_valid),
      .instr           (instr),
      .use_imm         (use_imm),
      .amt_reg         (amt_reg),
      .hi_word         (hi_word),
      .lo_word         (lo_word),
      .out_valid       (out_valid),
      .out_result      (out_result),
      .out_unsupported (out_unsupported)
   );

   initial begin
      clk = 1'b0;
      forever #5 clk = ~clk;
   end

   // R1 field layout
   function automatic logic [63:0] mk(input logic [1:0] ty, input logic [1:0] xm,
                                      input logic wr, input logic cc, input logic [5:0] im);
      logic [63:0] w = '0;
      w[38:37] = ty;
      w[49:48] = xm;
      w[50]    = wr;
      w[47]    = cc;
      w[25:20] = im;
      return w;
   endfunction

   // expected value from R2..R6
   function automatic logic [31:0] model(input logic [1:0] ty, input logic wr, input logic ui,
                                         input logic [5:0] im, input logic [31:0] ar,
                                         input logic [31:0] hi, input logic [31:0] lo);
      int size = (ty == 2'd0) ? 32 : 64;
      longint s;
      logic [31:0] a, b;
      if (wr) s = ui ? longint'(im & (size - 1)) : longint'(ar & (size - 1));
      else begin
         s = ui ? longint'(im) : longint'($signed(ar));
         if (s < 0) s = 0;
         if (s > size) s = size;
      end
      if (size == 32) begin
         a = (s == 32) ? 32'd0 : hi << s;
         b = (s == 0)  ? 32'd0 : lo >> (32 - s);
         return a | b;
      end
      if (s == 0)  return hi;
      if (s < 32)  return (hi << s) | (lo >> (32 - s));
      if (s == 64) return 32'd0;
      return lo << (s - 32);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [63:0] ins, input logic ui, input logic [31:0] ar,
                        input logic [31:0] hi, input logic [31:0] lo);
      @(negedge clk);
      instr = ins; use_imm = ui; amt_reg = ar; hi_word = hi; lo_word = lo;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(input string tag, input logic [1:0] ty, input logic wr, input logic ui,
                      input logic [5:0] im, input logic [31:0] ar);
      logic [31:0] hi = 32'h8123_4567;
      logic [31:0] lo = 32'h89AB_CDEF;
      issue(mk(ty, 2'd0, wr, 1'b0, im), ui, ar, hi, lo);
      chk({tag, " result"}, out_result, model(ty, wr, ui, im, ar, hi, lo));
      chk("R8 valid strobe", {31'd0, out_valid}, 32'd1);
   endtask

   task automatic t_reset;
      chk("R10 reset valid",  {31'd0, out_valid}, 32'd0);
      chk("R10 reset result", out_result, 32'd0);
      chk("R10 reset flag",   {31'd0, out_unsupported}, 32'd0);
   endtask

   task automatic t_narrow;
      run("R5 imm 0 gives hi",      2'd0, 1'b0, 1'b1, 6'd0,  32'd0);
      chk("R5 exact hi", out_result, 32'h8123_4567);
      run("R5 imm 4",               2'd0, 1'b0, 1'b1, 6'd4,  32'd0);
      run("R5 imm 32 gives lo",     2'd0, 1'b0, 1'b1, 6'd32, 32'd0);
      chk("R5 exact lo", out_result, 32'h89AB_CDEF);
      run("R4 imm 40 clamps to 32", 2'd0, 1'b0, 1'b1, 6'd40, 32'd0);
      run("R3 imm 40 wraps to 8",   2'd0, 1'b1, 1'b1, 6'd40, 32'd0);
      run("R4 reg negative to 0",   2'd0, 1'b0, 1'b0, 6'd9,  32'hFFFF_FFFB);
      run("R4 reg 100 to 32",       2'd0, 1'b0, 1'b0, 6'd0,  32'd100);
      run("R3 reg 37 wraps to 5",   2'd0, 1'b1, 1'b0, 6'd0,  32'd37);
      run("R1 reg 17 over imm 3",   2'd0, 1'b0, 1'b0, 6'd3,  32'd17);
   endtask

   task automatic t_wide;
      run("R6 imm 0 gives hi",      2'd2, 1'b0, 1'b1, 6'd0,  32'd0);
      run("R6 imm 12",              2'd2, 1'b0, 1'b1, 6'd12, 32'd0);
      run("R6 imm 32 gives lo",     2'd2, 1'b0, 1'b1, 6'd32, 32'd0);
      run("R6 imm 45",              2'd2, 1'b0, 1'b1, 6'd45, 32'd0);
      chk("R6 exact 45", out_result, 32'h89AB_CDEF << 13);
      run("R6 reg 64 clears",       2'd2, 1'b0, 1'b0, 6'd0,  32'd64);
      chk("R6 exact zero", out_result, 32'd0);
      run("R4 reg 200 clamps to 64",2'd3, 1'b0, 1'b0, 6'd0,  32'd200);
      run("R3 reg 64 wraps to 0",   2'd3, 1'b1, 1'b0, 6'd0,  32'd64);
      run("R6 signed type imm 63",  2'd3, 1'b0, 1'b1, 6'd63, 32'd0);
      run("R2 type 1 is wide 40",   2'd1, 1'b0, 1'b1, 6'd40, 32'd0);
      run("R2 type 2 reg 33",       2'd2, 1'b0, 1'b0, 6'd0,  32'd33);
   endtask

   task automatic t_unsupported;
      logic [31:0] hi = 32'hDEAD_BEEF;
      logic [31:0] lo = 32'h0123_4567;
      for (int m = 1; m < 4; m++) begin
         issue(mk(2'd0, 2'(m), 1'b0, 1'b0, 6'd8), 1'b1, 32'd0, hi, lo);
         chk("R7 mode flag", {31'd0, out_unsupported}, 32'd1);
         chk("R7 mode result", out_result, model(2'd0, 1'b0, 1'b1, 6'd8, 32'd0, hi, lo));
      end
      issue(mk(2'd2, 2'd0, 1'b0, 1'b1, 6'd8), 1'b1, 32'd0, hi, lo);
      chk("R7 cc flag", {31'd0, out_unsupported}, 32'd1);
      issue(mk(2'd2, 2'd0, 1'b0, 1'b0, 6'd8), 1'b1, 32'd0, hi, lo);
      chk("R7 plain clears flag", {31'd0, out_unsupported}, 32'd0);
   endtask

   task automatic t_hold;
      logic [31:0] held;
      issue(mk(2'd0, 2'd1, 1'b0, 1'b0, 6'd7), 1'b1, 32'd0, 32'h1111_2222, 32'h3333_4444);
      held = out_result;
      instr = mk(2'd2, 2'd0, 1'b0, 1'b0, 6'd20);
      hi_word = 32'hFFFF_0000; lo_word = 32'h0000_FFFF;
      repeat (3) @(negedge clk);
      chk("R9 result held",  out_result, held);
      chk("R9 flag held",    {31'd0, out_unsupported}, 32'd1);
      chk("R9 valid low",    {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; instr = '0; use_imm = 1'b0;
      amt_reg = '0; hi_word = '0; lo_word = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_narrow();
      t_wide();
      t_unsupported();
      t_hold();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule